// File: doc/BRIEF.md
# SPDIF Subframe Deframer

This block sits behind a biphase line decoder. The decoder delivers one strobe per recovered data bit. It also gives a separate strobe with a two-bit code when it recognises a synchronisation preamble. The deframer uses each accepted preamble as the anchor for a subframe. It counts the 28 data slots that follow, slots 4 through 31. From those slots it assembles the audio sample, the validity, user and channel-status bits, and the even-parity result.

One clock after the final slot, every field is presented at once, with a single-cycle data enable and start flags for the channel and the block. Those flags are also one cycle wide. The channel-A preambles drive a counter that gives each frame its position inside the 192-frame block.

The output sample width is a parameter from 16 to 24 bits. The 24-bit word is built with the four auxiliary bits as its lowest bits. A narrower output keeps the most significant bits of that word.

Top module: `spdif_deframer`

## Requirements
- R1: While reset is asserted, and after it until the first subframe completes, the data enable, all start flags, the sample, the frame index, and the validity, user, channel-status and parity-error outputs are 0.
- R2: Slots 4..27 arrive least significant bit first. Slots 4..7 form bits 3..0 of a 24-bit word, and slots 8..27 form bits 23..4. The sample output is the top WIDTH bits of that word, so WIDTH=16 gives word bits 23..8.
- R3: The bit in slot 28 appears on the validity output, slot 29 on the user output and slot 30 on the channel-status output. These outputs, the sample and the frame index hold their values until the next data enable.
- R4: The parity-error output is 1 exactly when the XOR of slots 4..31 is 1. The value is shown with the data enable and held with the data.
- R5: The data enable is high for exactly one cycle, and that cycle is the one right after the clock edge that accepts the slot-31 bit strobe.
- R6: The preamble code is 0 for X, 1 for Y and 2 for Z. The channel-0 start flag pulses with the data enable for an X or Z subframe. The channel-1 start flag pulses with the data enable for a Y subframe.
- R7: A Z subframe pulses the block-start flag and reports frame index 0. Each X subframe reports the previous index plus one, and wraps from 191 to 0 without a block-start flag. Reset loads the counter so that a first X reports 0.
- R8: A Z preamble resets the frame index to 0 at any count, not only after 191.
- R9: An accepted preamble arriving before slot 31 discards the partial subframe and restarts at slot 4. Bit strobes that arrive with no subframe open produce no data enable.
- R10: A preamble strobe with code 3 is ignored, including when it arrives in the middle of a subframe. A bit strobe in the same cycle as an accepted preamble is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe for a decoded data bit |
| bit_val | input | 1 | Value of the decoded bit |
| pre_stb | input | 1 | One-cycle strobe for a detected preamble |
| pre_kind | input | 2 | Preamble code: 0 X, 1 Y, 2 Z, 3 ignored |
| smp | output | WIDTH | Audio sample, most significant bits of the 24-bit word |
| smp_de | output | 1 | One-cycle data enable, aligned with smp |
| vbit | output | 1 | Validity bit (slot 28) |
| ubit | output | 1 | User bit (slot 29) |
| cbit | output | 1 | Channel-status bit (slot 30) |
| par_err | output | 1 | Even-parity failure of the subframe |
| sf0_start | output | 1 | Channel-0 subframe flag |
| sf1_start | output | 1 | Channel-1 subframe flag |
| blk_start | output | 1 | Block start flag |
| frame_idx | output | 8 | Frame position inside the block |

## Verification
If the slot counter drifts by even one position, every field shifts at once. The sample shows up doubled or halved, the flag bits swap, and the parity error rises on the very next data enable. A counter that has stopped or wrapped wrongly shows the wrong frame index, or a missing block flag, at the next channel-A subframe. Stale open-subframe state would show up as an extra or missing enable after stray bits, so the bench compares the total count of enables with the count of subframes it completed.

// File: rtl/spdif_deframer.sv
module spdif_deframer #(
  parameter int WIDTH  = 24,
  parameter int FRAMES = 192
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_stb,
  input  logic                       bit_val,
  input  logic                       pre_stb,
  input  logic [1:0]                 pre_kind,
  output logic [WIDTH-1:0]           smp,
  output logic                       smp_de,
  output logic                       vbit,
  output logic                       ubit,
  output logic                       cbit,
  output logic                       par_err,
  output logic                       sf0_start,
  output logic                       sf1_start,
  output logic                       blk_start,
  output logic [$clog2(FRAMES)-1:0]  frame_idx
);
  localparam int SW = 24;
  localparam int FW = $clog2(FRAMES);
  localparam logic [1:0] K_X = 2'd0, K_Y = 2'd1, K_Z = 2'd2;
  localparam logic [FW-1:0] F_LAST = FW'(FRAMES - 1);

  initial assert (WIDTH >= 16 && WIDTH <= SW);

  logic          open_q;
  logic [4:0]    slot;
  logic [SW-1:0] sh;
  logic          v_q, u_q, c_q, par_q;
  logic [1:0]    kind_q;
  logic [FW-1:0] fcnt;

  wire pre_ok = pre_stb && (pre_kind != 2'd3);
  wire take   = bit_stb && open_q && !pre_ok;
  wire last   = take && (slot == 5'd31);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      slot   <= 5'd0;
      sh     <= '0;
      v_q    <= 1'b0;
      u_q    <= 1'b0;
      c_q    <= 1'b0;
      par_q  <= 1'b0;
      kind_q <= K_X;
      fcnt   <= F_LAST;
    end else if (pre_ok) begin
      open_q <= 1'b1;
      slot   <= 5'd4;
      par_q  <= 1'b0;
      kind_q <= pre_kind;
      if (pre_kind == K_Z)      fcnt <= '0;
      else if (pre_kind == K_X) fcnt <= (fcnt == F_LAST) ? '0 : fcnt + 1'b1;
    end else if (take) begin
      slot  <= slot + 5'd1;
      par_q <= par_q ^ bit_val;
      if (slot < 5'd28) sh <= {bit_val, sh[SW-1:1]};
      if (slot == 5'd28) v_q <= bit_val;
      if (slot == 5'd29) u_q <= bit_val;
      if (slot == 5'd30) c_q <= bit_val;
      if (slot == 5'd31) open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp       <= '0;
      smp_de    <= 1'b0;
      vbit      <= 1'b0;
      ubit      <= 1'b0;
      cbit      <= 1'b0;
      par_err   <= 1'b0;
      sf0_start <= 1'b0;
      sf1_start <= 1'b0;
      blk_start <= 1'b0;
      frame_idx <= '0;
    end else begin
      smp_de    <= last;
      sf0_start <= last && (kind_q != K_Y);
      sf1_start <= last && (kind_q == K_Y);
      blk_start <= last && (kind_q == K_Z);
      if (last) begin
        smp       <= sh[SW-1 -: WIDTH];
        vbit      <= v_q;
        ubit      <= u_q;
        cbit      <= c_q;
        par_err   <= par_q ^ bit_val;
        frame_idx <= fcnt;
      end
    end
  end

  // R5
  de_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_de |=> !smp_de);
  // R5
  de_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_de |-> $past(bit_stb));
  // R6
  sf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_de |-> $onehot({sf0_start, sf1_start}));
  // R6
  flags_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_de |-> !(sf0_start || sf1_start || blk_start));
  // R7
  blk_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> (sf0_start && frame_idx == '0));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx <= F_LAST);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_de |-> ($stable(smp) && $stable(frame_idx) && $stable(par_err)));
endmodule

// File: tb/spdif_deframer_test.sv
`timescale 1ns/1ps
module spdif_deframer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, bit_val = 1'b0, pre_stb = 1'b0;
  logic [1:0] pre_kind = 2'd0;
  logic [23:0] smp;
  logic [15:0] smp_n;
  logic smp_de, vbit, ubit, cbit, par_err, sf0, sf1, blk;
  logic smp_de_n, vbit_n, ubit_n, cbit_n, par_err_n, sf0_n, sf1_n, blk_n;
  logic [7:0] fidx, fidx_n;

  int checks = 0, fails = 0, de_seen = 0, de_exp = 0;
  int exp_f = 191;

  always #2.5 clk = ~clk;

  spdif_deframer #(.WIDTH(24)) uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .pre_stb(pre_stb), .pre_kind(pre_kind), .smp(smp), .smp_de(smp_de),
    .vbit(vbit), .ubit(ubit), .cbit(cbit), .par_err(par_err),
    .sf0_start(sf0), .sf1_start(sf1), .blk_start(blk), .frame_idx(fidx));

  spdif_deframer #(.WIDTH(16)) uut_n (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .pre_stb(pre_stb), .pre_kind(pre_kind), .smp(smp_n), .smp_de(smp_de_n),
    .vbit(vbit_n), .ubit(ubit_n), .cbit(cbit_n), .par_err(par_err_n),
    .sf0_start(sf0_n), .sf1_start(sf1_n), .blk_start(blk_n), .frame_idx(fidx_n));

  always @(negedge clk) if (rst_n && smp_de) de_seen++;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic par_of(input logic [23:0] w, input logic v, input logic u, input logic c);
    return ^{w, v, u, c};
  endfunction

  task automatic gap();
    int g = $urandom % 3;
    repeat (g) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    bit_stb = 1'b1; bit_val = b;
    @(negedge clk);
    bit_stb = 1'b0;
    gap();
  endtask

  task automatic advance(input int kind);
    if (kind == 2) exp_f = 0;
    else if (kind == 0) exp_f = (exp_f == 191) ? 0 : exp_f + 1;
  endtask

  // inj: 0 none, 1 code-3 preamble mid-subframe (R10), 2 bit with the preamble (R10)
  task automatic send_sf(input int kind, input logic [23:0] w, input logic v, input logic u,
                         input logic c, input logic bad, input int inj);
    logic [27:0] pl;
    pl = {par_of(w, v, u, c) ^ bad, c, u, v, w};
    pre_stb = 1'b1; pre_kind = 2'(kind);
    if (inj == 2) begin bit_stb = 1'b1; bit_val = 1'b1; end
    @(negedge clk);
    pre_stb = 1'b0; bit_stb = 1'b0;
    advance(kind);
    gap();
    for (int i = 0; i < 27; i++) begin
      if (inj == 1 && i == 10) begin
        pre_stb = 1'b1; pre_kind = 2'd3;
        @(negedge clk);
        pre_stb = 1'b0;
      end
      drive_bit(pl[i]);
    end
    bit_stb = 1'b1; bit_val = pl[27];
    @(negedge clk);
    bit_stb = 1'b0;
    de_exp++;
    chk(smp_de == 1'b1, "R5 enable", 32'(smp_de), 1);
    chk(smp == w, "R2 sample24", 32'(smp), 32'(w));
    chk(smp_n == w[23:8], "R2 sample16", 32'(smp_n), 32'(w[23:8]));
    chk({vbit, ubit, cbit} == {v, u, c}, "R3 v/u/c", 32'({vbit, ubit, cbit}), 32'({v, u, c}));
    chk(par_err == bad, "R4 parity", 32'(par_err), 32'(bad));
    chk(sf0 == (kind != 1) && sf1 == (kind == 1), "R6 channel flags", 32'({sf0, sf1}),
        32'({kind != 1, kind == 1}));
    chk(blk == (kind == 2), "R7 block flag", 32'(blk), 32'(kind == 2));
    if (kind != 1) chk(fidx == 8'(exp_f), "R7 frame index", 32'(fidx), 32'(exp_f));
    @(negedge clk);
    chk(smp_de == 1'b0 && sf0 == 1'b0 && sf1 == 1'b0, "R5 one-cycle", 32'({smp_de, sf0, sf1}), 0);
    chk(smp == w && par_err == bad, "R3 hold", 32'(smp), 32'(w));
  endtask

  task automatic partial(input int kind, input int n);
    pre_stb = 1'b1; pre_kind = 2'(kind);
    @(negedge clk);
    pre_stb = 1'b0;
    advance(kind);
    for (int i = 0; i < n; i++) drive_bit(1'($urandom));
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'($urandom));
    repeat (2) @(negedge clk);
    chk(de_seen == de_exp, "R9 stray bits", 32'(de_seen), 32'(de_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1
    chk(smp_de == 0 && sf0 == 0 && sf1 == 0 && blk == 0, "R1 flags in reset", 32'({smp_de, sf0, sf1, blk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp == 0 && fidx == 0 && {vbit, ubit, cbit, par_err} == 0, "R1 data after reset",
        32'(smp), 0);
    stray(40);

    send_sf(0, 24'h800001, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    send_sf(1, 24'h00000F, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    send_sf(0, 24'hFFFFF0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    send_sf(1, 24'h123456, 1'b1, 1'b1, 1'b1, 1'b1, 0);
    stray(35);

    for (int f = 0; f < 192; f++) begin
      send_sf(f == 0 ? 2 : 0, 24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 8) == 0, ($urandom % 6 == 0) ? 1 + ($urandom % 2) : 0);
      send_sf(1, 24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 8) == 0, 0);
    end
    // R7 wrap without Z: expected index 0 and no block flag
    send_sf(0, 24'hA5A5A5, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    chk(exp_f == 0, "R7 wrap model", 32'(exp_f), 0);
    send_sf(0, 24'h5A5A5A, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    send_sf(0, 24'h000100, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // R8 early Z resync
    send_sf(2, 24'h7FFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    send_sf(0, 24'h010203, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    // R9 abort partial subframes
    partial(1, 12);
    send_sf(1, 24'hC0FFEE, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    partial(0, 27);
    send_sf(2, 24'hBEEF01, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    chk(de_seen == de_exp, "R9 enable count", 32'(de_seen), 32'(de_exp));
    // R10 directed
    send_sf(0, 24'h00FF00, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    send_sf(1, 24'hFF00FF, 1'b1, 1'b1, 1'b1, 1'b0, 2);
    stray(30);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule